// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of already-synchronised GPIO input levels and turns them into interrupt requests. Each pin has four configuration bits: an enable, a mask, a trigger type and a trigger polarity. Together, type and polarity pick one of four trigger modes: rising edge, falling edge, high level or low level. Edge events are held in sticky status bits. Level conditions follow the pin each cycle.

The block exposes two status words. The raw word holds the pending events of every enabled pin, whether masked or not. The masked word is the raw word with masked pins removed. A single interrupt line is the registered OR of the masked word.

Software acknowledges edge events through two end-of-interrupt words, one for each half of the bank. Both use a per-bit write-enable format: data bit n counts only when its enable bit n+N/2 is also written as 1.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is held, and in the first cycle after it, `raw_status`, `int_status` and `irq` are all 0.
- R2: With type=1 and polarity=1 (rising edge), an enabled pin sampled at 1 after having been sampled at 0 on the previous clock sets its `raw_status` bit after that clock edge. The very first sample after reset never counts as an edge.
- R3: With type=1 and polarity=0 (falling edge), an enabled pin sampled at 0 after having been sampled at 1 sets its `raw_status` bit after that clock edge.
- R4: With type=0, an enabled pin's `raw_status` bit equals (pin level == polarity) as sampled at the previous clock edge. Polarity 1 means active high and polarity 0 means active low. End-of-interrupt writes have no effect on level pins.
- R5: A latched edge bit stays set until an end-of-interrupt clears it. For pins 0..N/2-1, `eoi_lo_wr` with data bit n=1 and enable bit n+N/2=1 clears pin n. For pins N/2..N-1, `eoi_hi_wr` with data bit k=1 and enable bit k+N/2=1 clears pin N/2+k. A data bit written without its enable bit is ignored.
- R6: If a new edge and a clearing end-of-interrupt hit the same pin in the same cycle, the bit stays set.
- R7: A pin whose enable bit is 0 has its `raw_status` bit cleared on the next clock, and it latches no events.
- R8: `int_status` equals `raw_status` AND NOT `irq_mask`. A mask bit of 1 hides the pin without changing its raw bit, and all pins may be enabled while all are masked.
- R9: `irq` is 1 exactly one clock after a cycle in which any `int_status` bit is 1.
- R10: Changing a pin's type or polarity while its level is steady creates no edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | N | Synchronised pin levels |
| irq_enable | input | N | Per-pin detection enable |
| irq_mask | input | N | Per-pin mask, 1 hides the pin |
| trig_type | input | N | 1 = edge trigger, 0 = level trigger |
| trig_pol | input | N | 1 = rising/high, 0 = falling/low |
| eoi_lo_wr | input | 1 | Write strobe, low-half end-of-interrupt word |
| eoi_lo_data | input | N | Low-half word: data in bits [N/2-1:0], enables above |
| eoi_hi_wr | input | 1 | Write strobe, high-half end-of-interrupt word |
| eoi_hi_data | input | N | High-half word: data in bits [N/2-1:0], enables above |
| raw_status | output | N | Pending events of enabled pins |
| int_status | output | N | Raw status with masked pins removed |
| irq | output | 1 | Registered OR of `int_status` |

## Verification
The assertions assume that `pin_level` is already synchronised, so it changes only between clock edges. They also assume the configuration inputs are driven by registers, which means the values at one edge are the ones that decide the next state. The bench drives every input on the falling clock edge, so each value is stable across the rising edge that samples it. The bench runs directed phases for each trigger mode, the end-of-interrupt enable format, collisions between an edge and an acknowledge, and masking. It then runs a randomised stretch that also flips type and polarity while the pins are held steady.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Trigger mode is the concatenation {type, polarity}.
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic en;
        logic typ;
        logic pol;
    } pin_cfg_t;

    function automatic trig_mode_e decode_trig(input logic typ, input logic pol);
        return trig_mode_e'({typ, pol});
    endfunction

    function automatic logic mode_is_edge(input trig_mode_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL);
    endfunction

endpackage

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    input  pin_cfg_t cfg,
    input  logic     eoi_clr,
    output logic     raw
);

    logic       prev_q;
    logic       hist_q;
    logic       edge_q;
    logic       level_q;
    logic       hit;
    logic       lvl_active;
    trig_mode_e mode;

    assign mode = decode_trig(cfg.typ, cfg.pol);

    always_comb begin
        hit        = 1'b0;
        lvl_active = 1'b0;
        case (mode)
            TRIG_RISE: hit        = hist_q & lvl & ~prev_q;
            TRIG_FALL: hit        = hist_q & ~lvl & prev_q;
            TRIG_HIGH: lvl_active = lvl;
            TRIG_LOW:  lvl_active = ~lvl;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            hist_q  <= 1'b0;
            edge_q  <= 1'b0;
            level_q <= 1'b0;
        end else begin
            prev_q  <= lvl;
            hist_q  <= 1'b1;
            edge_q  <= cfg.en & mode_is_edge(mode) & (hit | (edge_q & ~eoi_clr));
            level_q <= cfg.en & lvl_active;
        end
    end

    assign raw = edge_q | level_q;

    // R7: a disabled pin shows no status on the next cycle
    a_r7_disabled_clear: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> !raw);

    // R5: a latched edge holds while nothing acknowledges it
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.typ && edge_q && !eoi_clr) |=> raw);

    // R5: acknowledge with no new edge drops the bit
    a_r5_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg.typ && eoi_clr && !hit) |=> !raw);

    // R6: a new edge wins over a same-cycle acknowledge
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && hit) |=> raw);

    // R10: a steady level never produces an edge
    a_r10_steady_no_edge: assert property (@(posedge clk) disable iff (rst)
        (hist_q && lvl == prev_q) |-> !hit);

endmodule

// File: rtl/eoi_decode.sv
module eoi_decode #(
    parameter int N = 32
) (
    input  logic         lo_wr,
    input  logic [N-1:0] lo_word,
    input  logic         hi_wr,
    input  logic [N-1:0] hi_word,
    output logic [N-1:0] clr
);

    localparam int HALF = N / 2;

    for (genvar i = 0; i < HALF; i++) begin : g_half
        assign clr[i]        = lo_wr & lo_word[i] & lo_word[i + HALF];
        assign clr[i + HALF] = hi_wr & hi_word[i] & hi_word[i + HALF];
    end

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] masked,
    output logic         irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked;
    end

    assign irq = irq_q;

    // R9: any masked bit raises the line one cycle later
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
        (masked != '0) |=> irq);

    // R9: quiet status leaves the line low one cycle later
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (masked == '0) |=> !irq);

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_level,
    input  logic [N-1:0] irq_enable,
    input  logic [N-1:0] irq_mask,
    input  logic [N-1:0] trig_type,
    input  logic [N-1:0] trig_pol,
    input  logic         eoi_lo_wr,
    input  logic [N-1:0] eoi_lo_data,
    input  logic         eoi_hi_wr,
    input  logic [N-1:0] eoi_hi_data,
    output logic [N-1:0] raw_status,
    output logic [N-1:0] int_status,
    output logic         irq
);

    logic [N-1:0] eoi_clr;

    eoi_decode #(.N(N)) u_eoi (
        .lo_wr   (eoi_lo_wr),
        .lo_word (eoi_lo_data),
        .hi_wr   (eoi_hi_wr),
        .hi_word (eoi_hi_data),
        .clr     (eoi_clr)
    );

    for (genvar p = 0; p < N; p++) begin : g_pin
        pin_cfg_t cfg;
        assign cfg = '{en: irq_enable[p], typ: trig_type[p], pol: trig_pol[p]};

        irq_pin_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .lvl     (pin_level[p]),
            .cfg     (cfg),
            .eoi_clr (eoi_clr[p]),
            .raw     (raw_status[p])
        );
    end

    assign int_status = raw_status & ~irq_mask;

    irq_combine #(.N(N)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .masked (int_status),
        .irq    (irq)
    );

    // R8: no masked pin ever reaches the status word
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (int_status & irq_mask) == '0);

    // R1: first cycle after reset shows nothing pending
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (raw_status == '0 && !irq));

endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;

    localparam int N = 32;
    localparam int H = N / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_level = '0;
    logic [N-1:0] irq_enable = '0;
    logic [N-1:0] irq_mask = '0;
    logic [N-1:0] trig_type = '0;
    logic [N-1:0] trig_pol = '0;
    logic         eoi_lo_wr = 1'b0;
    logic [N-1:0] eoi_lo_data = '0;
    logic         eoi_hi_wr = 1'b0;
    logic [N-1:0] eoi_hi_data = '0;
    logic [N-1:0] raw_status;
    logic [N-1:0] int_status;
    logic         irq;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";

    always #2.5 clk = ~clk;

    gpio_irq_detect #(.N(N)) uut (.*);

    // Behavioural reference model
    logic [N-1:0] m_edge, m_level, m_prev;
    logic         m_seen, m_irq;

    always @(posedge clk) begin
        logic [N-1:0] ne, nl;
        logic         clr;
        if (rst) begin
            m_edge <= '0; m_level <= '0; m_prev <= '0; m_seen <= 1'b0; m_irq <= 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (i < H) clr = eoi_lo_wr && eoi_lo_data[i] && eoi_lo_data[i+H];
                else       clr = eoi_hi_wr && eoi_hi_data[i-H] && eoi_hi_data[i];
                ne[i] = 1'b0;
                nl[i] = 1'b0;
                if (irq_enable[i]) begin
                    if (trig_type[i]) begin
                        if (m_seen && trig_pol[i] && pin_level[i] && !m_prev[i]) ne[i] = 1'b1;
                        else if (m_seen && !trig_pol[i] && !pin_level[i] && m_prev[i]) ne[i] = 1'b1;
                        else ne[i] = m_edge[i] && !clr;
                    end else begin
                        nl[i] = (pin_level[i] == trig_pol[i]);
                    end
                end
            end
            m_irq   <= ((m_edge | m_level) & ~irq_mask) != '0;
            m_edge  <= ne;
            m_level <= nl;
            m_prev  <= pin_level;
            m_seen  <= 1'b1;
        end
    end

    task automatic compare();
        logic [N-1:0] er, em;
        er = rst ? '0 : (m_edge | m_level);
        em = er & ~irq_mask;
        n_tests++;
        if (raw_status !== er) begin
            n_fail++;
            $display("FAIL %s raw_status actual=%h expected=%h", phase, raw_status, er);
        end
        n_tests++;
        if (int_status !== em) begin
            n_fail++;
            $display("FAIL %s int_status actual=%h expected=%h", phase, int_status, em);
        end
        n_tests++;
        if (irq !== (rst ? 1'b0 : m_irq)) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", phase, irq, m_irq);
        end
    endtask

    task automatic cyc(int k = 1);
        for (int j = 0; j < k; j++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic eoi(logic lo, logic [N-1:0] d);
        if (lo) begin eoi_lo_wr = 1'b1; eoi_lo_data = d; end
        else    begin eoi_hi_wr = 1'b1; eoi_hi_data = d; end
        cyc();
        eoi_lo_wr = 1'b0; eoi_hi_wr = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        phase = "R1";
        pin_level = 32'hA5A5_0F0F;
        irq_enable = '1; trig_type = '1; trig_pol = '1;
        cyc(2);
        rst = 1'b0;
        cyc(2);

        phase = "R10";
        trig_pol = 32'h0000_FFFF; cyc(2);
        trig_type = 32'hFFFF_0000; cyc(2);
        trig_type = '1; trig_pol = '1; cyc(2);

        phase = "R2";
        pin_level = pin_level ^ 32'h0F0F_F0F0; cyc(3);

        phase = "R5";
        eoi(1'b1, 32'h0000_FFFF);
        cyc();
        eoi(1'b1, 32'h00F0_00F0);
        eoi(1'b0, 32'hFFFF_0F00);
        cyc(2);

        phase = "R3";
        trig_pol = '0;
        pin_level = pin_level ^ 32'hFFFF_FFFF; cyc(2);

        phase = "R6";
        pin_level = pin_level ^ 32'h0003_0003;
        eoi_lo_wr = 1'b1; eoi_lo_data = '1;
        eoi_hi_wr = 1'b1; eoi_hi_data = '1;
        cyc();
        eoi_lo_wr = 1'b0; eoi_hi_wr = 1'b0;
        cyc(2);

        phase = "R4";
        trig_type = '0; trig_pol = 32'hFF00_FF00;
        cyc(2);
        eoi(1'b1, '1);
        pin_level = 32'h1234_5678; cyc(2);

        phase = "R8";
        irq_mask = '1; cyc(3);
        irq_mask = 32'hFFFF_0000; cyc(2);
        irq_mask = 32'h0000_FFFF; cyc(2);

        phase = "R7";
        irq_mask = '0;
        irq_enable = 32'h00FF_00FF; cyc(2);
        irq_enable = '0; cyc(2);
        pin_level = ~pin_level; cyc(2);

        phase = "R9";
        irq_enable = '1;
        for (int r = 0; r < 400; r++) begin
            pin_level  = pin_level ^ ($urandom() & $urandom());
            irq_mask   = $urandom() | $urandom();
            if ((r % 5) == 0) trig_type = $urandom();
            if ((r % 7) == 0) trig_pol  = $urandom();
            if ((r % 11) == 0) irq_enable = ~($urandom() & $urandom() & $urandom());
            eoi_lo_wr   = ($urandom() % 3) == 0;
            eoi_lo_data = $urandom();
            eoi_hi_wr   = ($urandom() % 3) == 0;
            eoi_hi_data = $urandom();
            cyc();
        end
        eoi_lo_wr = 1'b0; eoi_hi_wr = 1'b0;

        phase = "R1";
        rst = 1'b1; cyc(2);
        rst = 1'b0; cyc();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog phase %s actual=timeout expected=done", phase);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule